// File: doc/BRIEF.md
# Masked Time-of-Day Alarm Comparator

This block holds three alarm registers (minutes, hours, day of week) on a byte-wide register bus. It compares them against the live time fields that the clock block supplies. Each alarm register carries a mask bit in bit 7. A set mask takes that field out of the comparison. Nesting the masks from the day down to the minute gives a one-shot weekly alarm, a daily alarm, an hourly alarm or an alarm every minute.

The clock block raises `chk_stb` once per second, during the period when its hundredths count reads 99. With the strobe it raises `sec_wrap` when the seconds are about to roll from 59 to 00. The time fields it presents at that moment are the values that take effect at the rollover. An alarm is evaluated only when both `chk_stb` and `sec_wrap` are high.

A match sets a sticky flag. The interrupt output follows the flag while interrupts are enabled. The host acknowledges the alarm by reading or writing any of the three alarm registers.

Top module: `tod_alarm_cmp`

## Requirements
- R1: After a synchronous active-low reset, `alarm_flag` and `alarm_irq` are 0, and all three alarm registers read 0x00.
- R2: Writes to address 3 (minutes alarm) and address 5 (hours alarm) store all 8 bits, and reads return them unchanged. In the hours alarm, bit 6 selects 12-hour format and bit 5 is the PM bit.
- R3: The day alarm at address 7 keeps bit 7 (mask) and bits 2:0 (day). Its bits 6:3 always read 0.
- R4: Bit 7 of each alarm register is its mask. With all masks 0, the flag sets only when minutes (bits 6:0), hours (bits 6:0, including the 12/24 and PM bits) and day (bits 2:0) all match.
- R5: With only the day mask set, the flag sets when minutes and hours match, whatever the day.
- R6: With the day and hours masks set, the flag sets on a minutes match alone.
- R7: With all three masks set, the flag sets at every check that has `sec_wrap` high.
- R8: The flag sets only in a cycle where both `chk_stb` and `sec_wrap` are high. Matching fields have no effect otherwise.
- R9: Once set, the flag stays set across later checks, whether or not they match.
- R10: A read or write of address 3, 5 or 7 clears the flag on the next clock edge. An access to any other address leaves the flag unchanged.
- R11: When an alarm-register access and a new match occur in the same cycle, the flag ends up 0.
- R12: `alarm_irq` is high exactly when the flag is set and `irq_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data of the addressed alarm register, 0 for other addresses |
| chk_stb | input | 1 | Once-per-second check strobe from the clock block |
| sec_wrap | input | 1 | Seconds are rolling from 59 to 00 at this check |
| cur_min | input | 7 | Current BCD minutes |
| cur_hour | input | 7 | Current hours, BCD with 12/24 and PM bits |
| cur_day | input | 3 | Current day of week |
| irq_en | input | 1 | Interrupt enable |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a register access that lands in the same cycle as a matching check. In normal use the host and the clock block are not aligned, so the two almost never coincide. The stimulus forces the collision by raising the read strobe and both check inputs in one driven cycle. It then confirms that the flag stays clear afterwards. A second difficulty is telling the mask modes apart. For this, each mode is run with a time that matches the unmasked fields but differs in a masked one, and then with a time that breaks an unmasked field.

// File: rtl/tod_alarm_pkg.sv
// Shared types for the time-of-day alarm comparator.
// Assumes BCD minutes in 7 bits, hours in 7 bits (with format and PM bits)
// and a 3-bit day of week.
package tod_alarm_pkg;
    localparam int MIN_W  = 7;
    localparam int HOUR_W = 7;
    localparam int DAY_W  = 3;

    typedef struct packed {
        logic              min_mask;
        logic [MIN_W-1:0]  min;
        logic              hour_mask;
        logic [HOUR_W-1:0] hour;
        logic              day_mask;
        logic [DAY_W-1:0]  day;
    } alarm_cfg_t;
endpackage

// File: rtl/alarm_regfile.sv
// Alarm register bank on a byte-wide bus.
// Holds the minutes, hours and day alarm registers at parameterised addresses.
// Reads are combinational; unimplemented day bits read 0. Reports any access
// (read or write) to one of its own addresses so the flag logic can clear.
// Assumes one-cycle read and write strobes.
module alarm_regfile
    import tod_alarm_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int MIN_ADDR  = 3,
    parameter int HOUR_ADDR = 5,
    parameter int DAY_ADDR  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              wr,
    input  logic              rd,
    output logic [7:0]        rdata,
    output logic              access,
    output alarm_cfg_t        cfg
);
    localparam int PAD_W = 7 - DAY_W;

    logic sel_min, sel_hour, sel_day;

    // Address decode for the three alarm slots.
    always_comb begin
        sel_min  = (addr == ADDR_W'(MIN_ADDR));
        sel_hour = (addr == ADDR_W'(HOUR_ADDR));
        sel_day  = (addr == ADDR_W'(DAY_ADDR));
    end

    assign access = (wr || rd) && (sel_min || sel_hour || sel_day);

    // Register writes; day keeps only its mask and day-number bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr) begin
            if (sel_min) begin
                cfg.min_mask <= wdata[7];
                cfg.min      <= wdata[MIN_W-1:0];
            end
            if (sel_hour) begin
                cfg.hour_mask <= wdata[7];
                cfg.hour      <= wdata[HOUR_W-1:0];
            end
            if (sel_day) begin
                cfg.day_mask <= wdata[7];
                cfg.day      <= wdata[DAY_W-1:0];
            end
        end
    end

    // Read mux; addresses outside the bank return 0.
    always_comb begin
        rdata = 8'h00;
        if (sel_min)  rdata = {cfg.min_mask, cfg.min};
        if (sel_hour) rdata = {cfg.hour_mask, cfg.hour};
        if (sel_day)  rdata = {cfg.day_mask, {PAD_W{1'b0}}, cfg.day};
    end
endmodule

// File: rtl/alarm_match.sv
// Masked field comparator.
// Each field takes part in the match unless its mask bit is set; a match
// counts only at a check strobe that coincides with the seconds rollover.
// Assumes time inputs hold the values that take effect at that rollover.
module alarm_match
    import tod_alarm_pkg::*;
(
    input  alarm_cfg_t        cfg,
    input  logic              chk_stb,
    input  logic              sec_wrap,
    input  logic [MIN_W-1:0]  cur_min,
    input  logic [HOUR_W-1:0] cur_hour,
    input  logic [DAY_W-1:0]  cur_day,
    output logic              hit
);
    logic [2:0] field_ok;

    // Per-field pass: masked or equal.
    always_comb begin
        field_ok[0] = cfg.min_mask  || (cfg.min  == cur_min);
        field_ok[1] = cfg.hour_mask || (cfg.hour == cur_hour);
        field_ok[2] = cfg.day_mask  || (cfg.day  == cur_day);
        hit         = chk_stb && sec_wrap && (&field_ok);
    end
endmodule

// File: rtl/alarm_flag.sv
// Sticky alarm flag and interrupt gate.
// Sets on a hit, clears on any alarm-register access; the clear wins when
// both arrive in the same cycle. Interrupt follows the flag when enabled.
module alarm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic access,
    input  logic irq_en,
    output logic flag,
    output logic irq
);
    // Flag register: clear has priority over set.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag <= 1'b0;
        else if (access) flag <= 1'b0;
        else if (hit)    flag <= 1'b1;
    end

    assign irq = flag && irq_en;

    p_clear_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        access |=> !flag);
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !access) |=> flag);
endmodule

// File: rtl/tod_alarm_cmp.sv
// Masked time-of-day alarm comparator, top level.
// Joins the alarm register bank, the masked comparator and the sticky flag.
// Assumes the clock block drives chk_stb once per second and sec_wrap at the
// 59-to-00 seconds rollover.
module tod_alarm_cmp
    import tod_alarm_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int MIN_ADDR  = 3,
    parameter int HOUR_ADDR = 5,
    parameter int DAY_ADDR  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata,
    input  logic              chk_stb,
    input  logic              sec_wrap,
    input  logic [6:0]        cur_min,
    input  logic [6:0]        cur_hour,
    input  logic [2:0]        cur_day,
    input  logic              irq_en,
    output logic              alarm_flag,
    output logic              alarm_irq
);
    alarm_cfg_t cfg;
    logic       access;
    logic       hit;

    alarm_regfile #(
        .ADDR_W(ADDR_W), .MIN_ADDR(MIN_ADDR),
        .HOUR_ADDR(HOUR_ADDR), .DAY_ADDR(DAY_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata),
        .wr(bus_wr), .rd(bus_rd), .rdata(bus_rdata), .access(access), .cfg(cfg)
    );

    alarm_match u_match (
        .cfg(cfg), .chk_stb(chk_stb), .sec_wrap(sec_wrap),
        .cur_min(cur_min), .cur_hour(cur_hour), .cur_day(cur_day), .hit(hit)
    );

    alarm_flag u_flag (
        .clk(clk), .rst_n(rst_n), .hit(hit), .access(access),
        .irq_en(irq_en), .flag(alarm_flag), .irq(alarm_irq)
    );

    p_set_needs_check_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_flag ##1 alarm_flag) |-> $past(chk_stb && sec_wrap));
    p_all_masked_fires_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_stb && sec_wrap && cfg.min_mask && cfg.hour_mask && cfg.day_mask
         && !bus_wr && !bus_rd) |=> alarm_flag);
endmodule

// File: tb/tod_alarm_cmp_test.sv
`timescale 1ns/1ps
module tod_alarm_cmp_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       chk_stb = 1'b0, sec_wrap = 1'b0;
    logic [6:0] cur_min = '0, cur_hour = '0;
    logic [2:0] cur_day = '0;
    logic       irq_en = 1'b1;
    logic       alarm_flag, alarm_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        string      tag;
        int         kind;   // 0 flag, 1 irq, 2 rdata
        logic [7:0] exp;
    } item_t;
    item_t sb[$];

    always #2 clk = ~clk;

    tod_alarm_cmp uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .chk_stb(chk_stb), .sec_wrap(sec_wrap), .cur_min(cur_min),
        .cur_hour(cur_hour), .cur_day(cur_day), .irq_en(irq_en),
        .alarm_flag(alarm_flag), .alarm_irq(alarm_irq)
    );

    // Monitor: compares every queued expectation at the falling edge.
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = sb.pop_front();
            case (it.kind)
                0:       act = {7'b0, alarm_flag};
                1:       act = {7'b0, alarm_irq};
                default: act = bus_rdata;
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic push(input string tag, input int kind, input logic [7:0] exp);
        item_t it;
        it.tag = tag; it.kind = kind; it.exp = exp;
        sb.push_back(it);
    endtask

    task automatic expect_flag(input string tag, input logic f);
        push({tag, " flag"}, 0, {7'b0, f});
        push({tag, " irq"}, 1, {7'b0, f & irq_en});
        @(posedge clk); #1;
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input string tag, input logic [3:0] a, input logic [7:0] exp);
        @(posedge clk); #1;
        bus_addr = a; bus_rd = 1'b1;
        push(tag, 2, exp);
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic tick(input logic [6:0] m, input logic [6:0] h,
                        input logic [2:0] d, input logic chk, input logic wrap);
        @(posedge clk); #1;
        cur_min = m; cur_hour = h; cur_day = d; chk_stb = chk; sec_wrap = wrap;
        @(posedge clk); #1;
        chk_stb = 1'b0; sec_wrap = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        expect_flag("R1 reset", 1'b0);
        rd_reg("R1 min reg", 4'd3, 8'h00);
        rd_reg("R1 hour reg", 4'd5, 8'h00);
        rd_reg("R1 day reg", 4'd7, 8'h00);
        // R2 full-width storage
        wr_reg(4'd3, 8'h45);
        rd_reg("R2 min readback", 4'd3, 8'h45);
        wr_reg(4'd5, 8'h72);
        rd_reg("R2 hour readback 12h PM", 4'd5, 8'h72);
        // R3 day unused bits read 0
        wr_reg(4'd7, 8'hFF);
        rd_reg("R3 day readback", 4'd7, 8'h87);

        // R4 all masks clear
        wr_reg(4'd3, 8'h30); wr_reg(4'd5, 8'h14); wr_reg(4'd7, 8'h03);
        tick(7'h30, 7'h14, 3'd3, 1'b1, 1'b1);
        expect_flag("R4 full match", 1'b1);
        // R9 sticky across a mismatching check
        tick(7'h31, 7'h02, 3'd1, 1'b1, 1'b1);
        expect_flag("R9 sticky", 1'b1);
        // R10 access elsewhere keeps flag
        rd_reg("R10 other addr rdata", 4'd4, 8'h00);
        wr_reg(4'd6, 8'h55);
        expect_flag("R10 other addr", 1'b1);
        // R10 read clears
        rd_reg("R10 read min", 4'd3, 8'h30);
        expect_flag("R10 read clears", 1'b0);
        tick(7'h30, 7'h14, 3'd4, 1'b1, 1'b1);
        expect_flag("R4 day mismatch", 1'b0);
        // R8 no wrap / no strobe
        tick(7'h30, 7'h14, 3'd3, 1'b1, 1'b0);
        expect_flag("R8 no wrap", 1'b0);
        tick(7'h30, 7'h14, 3'd3, 1'b0, 1'b1);
        expect_flag("R8 no strobe", 1'b0);
        // R12 interrupt gating
        irq_en = 1'b0;
        tick(7'h30, 7'h14, 3'd3, 1'b1, 1'b1);
        expect_flag("R12 irq disabled", 1'b1);
        irq_en = 1'b1;
        expect_flag("R12 irq enabled", 1'b1);
        // R10 write clears
        wr_reg(4'd5, 8'h14);
        expect_flag("R10 write clears", 1'b0);

        // R5 day mask only; hour includes format and PM bits
        wr_reg(4'd7, 8'h83);
        tick(7'h30, 7'h14, 3'd5, 1'b1, 1'b1);
        expect_flag("R5 any day", 1'b1);
        wr_reg(4'd5, 8'h72);
        expect_flag("R5 cleared", 1'b0);
        tick(7'h30, 7'h52, 3'd5, 1'b1, 1'b1);
        expect_flag("R5 AM vs PM", 1'b0);
        tick(7'h31, 7'h72, 3'd5, 1'b1, 1'b1);
        expect_flag("R5 min mismatch", 1'b0);
        tick(7'h30, 7'h72, 3'd2, 1'b1, 1'b1);
        expect_flag("R5 PM match", 1'b1);

        // R6 day and hour masked
        wr_reg(4'd5, 8'h94);
        expect_flag("R6 cleared", 1'b0);
        tick(7'h29, 7'h09, 3'd6, 1'b1, 1'b1);
        expect_flag("R6 min mismatch", 1'b0);
        tick(7'h30, 7'h09, 3'd6, 1'b1, 1'b1);
        expect_flag("R6 any hour", 1'b1);

        // R7 all masked
        wr_reg(4'd3, 8'hB0);
        expect_flag("R7 cleared", 1'b0);
        tick(7'h12, 7'h05, 3'd1, 1'b1, 1'b0);
        expect_flag("R7 needs wrap", 1'b0);
        tick(7'h12, 7'h05, 3'd1, 1'b1, 1'b1);
        expect_flag("R7 every minute", 1'b1);

        // R11 access and match in the same cycle
        rd_reg("R11 read min", 4'd3, 8'hB0);
        @(posedge clk); #1;
        bus_addr = 4'd3; bus_rd = 1'b1; chk_stb = 1'b1; sec_wrap = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0; chk_stb = 1'b0; sec_wrap = 1'b0;
        expect_flag("R11 clear wins", 1'b0);

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule